// File: doc/BRIEF.md
# Word-Interleaved Block Memory

This block is a main memory made of four word-interleaved banks that sit behind a bus one word wide. It serves cache-block transfers of four 32-bit words. A request gives a word address and a direction. For a read, every bank starts its access in the same cycle. After that the four words leave the block one per cycle, in ascending address order, with a valid flag and a last-word flag. The long bank access therefore happens once per block and only the data transfer is serialized: one address cycle, six access cycles and four transfer cycles, eleven cycles in total.

The bank index is the low two bits of a word address, and the row inside the bank is the remaining upper bits, so consecutive words fall into consecutive banks. A full-block write stores one word in each bank during a single access period. A mode input turns interleaving off for comparison. In that mode each word pays its own address, access and transfer cycles, and a block costs 32 cycles.

Top module: `ilv_mem`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Word address A lives in bank A[1:0] at row A[9:2]. A block written in either mode reads back the same in either mode, and writes to one block leave every other block unchanged.
- R3: For an interleaved read accepted at clock edge E, `rsp_valid` is 1 right after edges E+7, E+8, E+9 and E+10, and is 0 again after E+11. The block is complete within 11 cycles of acceptance.
- R4: An interleaved read returns the four words in ascending address order as one unbroken run of exactly four valid cycles, with `rsp_last` set only on the fourth word.
- R5: With `interleave_en`=0 at acceptance, a read returns word k (k=0..3) as a single-cycle pulse right after edge E+7+8k. The last word comes after E+31, `rsp_last` marks it, and `req_ready` returns after E+32 (4×(1+6+1) = 32 cycles).
- R6: `req_ready` drops at acceptance and returns one cycle after the last word (after E+11 for an interleaved read). A request offered while `req_ready` is 0 is ignored and changes no stored word.
- R7: An interleaved write stores all four words in one access period, produces no `rsp_valid`, and `req_ready` returns after E+7.
- R8: The low two bits of `req_addr` are ignored. A request always covers the aligned four-word block that contains the address.
- R9: A non-interleaved write stores one word per round of 1+6 cycles, and `req_ready` returns after E+28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| interleave_en | input | 1 | 1: all banks access in parallel; 0: one word per full access round. Sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request this cycle |
| req_write | input | 1 | 1 = block write, 0 = block read |
| req_addr | input | 10 | Word address; the low two bits are ignored |
| req_wdata | input | 128 | Write block; word k at bits [32k+31:32k] |
| rsp_valid | output | 1 | `rsp_data` carries a read word |
| rsp_data | output | 32 | Read word |
| rsp_last | output | 1 | Marks the fourth word of a block |

## Verification
The assertions take for granted that the banks are started only from the idle-to-access path. They also assume that a request offered while `req_ready` is low has no effect, so the sequencer never sees overlapping blocks. The stimulus offers each normal request only after it sees `req_ready` high, and it reads only blocks that were written before. One deliberate exception holds a write request high for three cycles while a read is in flight and then withdraws it before `req_ready` returns. This exercises the ignore rule without leaving a pending request that would break the assumptions.

// File: rtl/ilv_mem_pkg.sv
package ilv_mem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ADDR   = 2'd1,
    ST_ACCESS = 2'd2,
    ST_XFER   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/ilv_mem_bank.sv
module ilv_mem_bank #(
  parameter int DATA_W     = 32,
  parameter int ROW_W      = 8,
  parameter int ACCESS_CYC = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  localparam int DEPTH = 1 << ROW_W;
  localparam int CNT_W = (ACCESS_CYC > 2) ? $clog2(ACCESS_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACCESS_CYC - 2);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              done_q;
  logic              we_q;
  logic [ROW_W-1:0]  row_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              finish;

  assign finish = busy_q && (cnt_q == '0);

  // latency counter: start edge plus ACCESS_CYC-1 further edges
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_LOAD;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      we_q    <= we;
      row_q   <= row;
      wdata_q <= wdata;
    end
  end

  // storage: single port, registered read, no reset
  always_ff @(posedge clk) begin
    if (finish) begin
      if (we_q) mem[row_q] <= wdata;
      else      rdata_q    <= mem[row_q];
    end
  end

  assign rdata = rdata_q;
  assign done  = done_q;

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy_q); // R6
  AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(busy_q)); // R3
  AST_DONE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R3

endmodule

// File: rtl/ilv_mem_bank_sel.sv
module ilv_mem_bank_sel #(
  parameter int NUM_BANKS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 ilv,
  input  logic [IDX_W-1:0]     word_idx,
  output logic [NUM_BANKS-1:0] start_vec
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    assign start_vec[b] = start && (ilv || (word_idx == IDX_W'(b)));
  end

  AST_SEQ_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
    !ilv |-> $onehot0(start_vec)); // R5

endmodule

// File: rtl/ilv_mem_seq.sv
module ilv_mem_seq
  import ilv_mem_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 4,
  parameter int IDX_W     = 2,
  parameter int ROW_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ilv_en,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ROW_W-1:0]            req_row,
  input  logic [NUM_BANKS*DATA_W-1:0] req_wdata,
  output logic                        req_ready,
  output logic                        acc_start,
  output logic                        acc_ilv,
  output logic                        acc_we,
  output logic [IDX_W-1:0]            acc_idx,
  output logic [ROW_W-1:0]            acc_row,
  output logic [NUM_BANKS*DATA_W-1:0] acc_wdata,
  input  logic [NUM_BANKS-1:0]        bank_done,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_data,
  output logic                        rsp_last
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANKS - 1);

  seq_state_e                  state_q;
  logic                        ready_q;
  logic [IDX_W-1:0]            idx_q;
  logic [IDX_W-1:0]            idx_nxt;
  logic                        ilv_q;
  logic                        we_q;
  logic [ROW_W-1:0]            row_q;
  logic [NUM_BANKS*DATA_W-1:0] wdata_q;
  logic                        rsp_valid_q;
  logic                        rsp_last_q;
  logic [DATA_W-1:0]           rsp_data_q;
  logic                        any_done;
  logic [DATA_W-1:0]           rd_cur;
  logic [DATA_W-1:0]           rd_nxt;
  logic                        at_last;

  assign idx_nxt  = idx_q + 1'b1;
  assign any_done = |bank_done;
  assign at_last  = (idx_q == LAST_IDX);
  assign rd_cur   = bank_rdata[idx_q*DATA_W +: DATA_W];
  assign rd_nxt   = bank_rdata[idx_nxt*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      ready_q     <= 1'b1;
      idx_q       <= '0;
      ilv_q       <= 1'b1;
      we_q        <= 1'b0;
      row_q       <= '0;
      wdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_last_q  <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid && ready_q) begin
            state_q <= ST_ADDR;
            ready_q <= 1'b0;
            idx_q   <= '0;
            ilv_q   <= ilv_en;
            we_q    <= req_write;
            row_q   <= req_row;
            wdata_q <= req_wdata;
          end
        end
        ST_ADDR: state_q <= ST_ACCESS;
        ST_ACCESS: begin
          if (any_done) begin
            if (we_q) begin
              if (ilv_q || at_last) begin
                state_q <= ST_IDLE;
                ready_q <= 1'b1;
              end else begin
                idx_q   <= idx_nxt;
                state_q <= ST_ADDR;
              end
            end else begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= rd_cur;
              rsp_last_q  <= at_last;
              state_q     <= ST_XFER;
            end
          end
        end
        ST_XFER: begin
          if (ilv_q && !at_last) begin
            idx_q      <= idx_nxt;
            rsp_data_q <= rd_nxt;
            rsp_last_q <= (idx_nxt == LAST_IDX);
          end else begin
            rsp_valid_q <= 1'b0;
            rsp_last_q  <= 1'b0;
            if (at_last) begin
              state_q <= ST_IDLE;
              ready_q <= 1'b1;
            end else begin
              idx_q   <= idx_nxt;
              state_q <= ST_ADDR;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = ready_q;
  assign acc_start = (state_q == ST_ADDR);
  assign acc_ilv   = ilv_q;
  assign acc_we    = we_q;
  assign acc_idx   = idx_q;
  assign acc_row   = row_q;
  assign acc_wdata = wdata_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_last  = rsp_last_q;

  AST_NO_ACCEPT_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_q |-> !ready_q); // R6
  AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_q && rsp_last_q) |=> !rsp_valid_q); // R4
  AST_ILV_BURST_UNBROKEN: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_q && !rsp_last_q && ilv_q) |=> rsp_valid_q); // R4
  AST_SEQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_q && !ilv_q) |=> !rsp_valid_q); // R5
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (we_q && state_q != ST_IDLE) |-> !rsp_valid_q); // R7
  AST_DONE_ONLY_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
    any_done |-> (state_q == ST_ACCESS)); // R3

endmodule

// File: rtl/ilv_mem.sv
module ilv_mem #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 10,
  parameter int NUM_BANKS  = 4,
  parameter int ACCESS_CYC = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        interleave_en,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [NUM_BANKS*DATA_W-1:0] req_wdata,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_data,
  output logic                        rsp_last
);

  localparam int IDX_W = $clog2(NUM_BANKS);
  localparam int ROW_W = ADDR_W - IDX_W;

  logic                        acc_start;
  logic                        acc_ilv;
  logic                        acc_we;
  logic [IDX_W-1:0]            acc_idx;
  logic [ROW_W-1:0]            acc_row;
  logic [NUM_BANKS*DATA_W-1:0] acc_wdata;
  logic [NUM_BANKS-1:0]        start_vec;
  logic [NUM_BANKS-1:0]        bank_done;
  logic [NUM_BANKS*DATA_W-1:0] bank_rdata;
  logic                        addr_lsb_unused;

  // the bank index comes from the word position, so address bits below the row are not used
  assign addr_lsb_unused = ^req_addr[IDX_W-1:0];

  ilv_mem_seq #(
    .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W), .ROW_W(ROW_W)
  ) seq_i (
    .clk(clk), .rst(rst), .ilv_en(interleave_en),
    .req_valid(req_valid), .req_write(req_write),
    .req_row(req_addr[ADDR_W-1:IDX_W]), .req_wdata(req_wdata),
    .req_ready(req_ready),
    .acc_start(acc_start), .acc_ilv(acc_ilv), .acc_we(acc_we),
    .acc_idx(acc_idx), .acc_row(acc_row), .acc_wdata(acc_wdata),
    .bank_done(bank_done), .bank_rdata(bank_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last)
  );

  ilv_mem_bank_sel #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) sel_i (
    .clk(clk), .rst(rst), .start(acc_start), .ilv(acc_ilv),
    .word_idx(acc_idx), .start_vec(start_vec)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ilv_mem_bank #(
      .DATA_W(DATA_W), .ROW_W(ROW_W), .ACCESS_CYC(ACCESS_CYC)
    ) bank_i (
      .clk(clk), .rst(rst), .start(start_vec[b]), .we(acc_we),
      .row(acc_row), .wdata(acc_wdata[b*DATA_W +: DATA_W]),
      .rdata(bank_rdata[b*DATA_W +: DATA_W]), .done(bank_done[b])
    );
  end

endmodule

// File: tb/ilv_mem_tb_top.sv
module ilv_mem_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         interleave_en = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [9:0]   req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_data;
  logic         rsp_last;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [31:0] ref_mem [0:1023];
  logic [31:0] q_data [$];
  int          q_cyc  [$];
  bit          q_last [$];
  string       q_tag  [$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ilv_mem dut_i (
    .clk(clk), .rst(rst), .interleave_en(interleave_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [127:0] pat(input int base, input int seed);
    logic [127:0] v;
    for (int k = 0; k < 4; k++) v[k*32 +: 32] = 32'h5A00_0000 ^ (base << 12) ^ (seed << 4) ^ k;
    return v;
  endfunction

  // scoreboard monitor: compares each returned word against the queued expectation
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q_data.size() == 0) begin
        chk(1'b0, "R7 unexpected rsp_valid", rsp_data, 0);
      end else begin
        logic [31:0] d;
        int          c;
        bit          l;
        string       t;
        d = q_data.pop_front();
        c = q_cyc.pop_front();
        l = q_last.pop_front();
        t = q_tag.pop_front();
        chk(rsp_data == d, {t, " R4 word data/order"}, rsp_data, d);
        chk(cyc == c, {t, " word cycle"}, cyc, c);
        chk(rsp_last == l, {t, " R4 last flag"}, rsp_last, l);
      end
    end
  end

  // driver: issues one request, pushes expectations, measures busy time
  task automatic do_req(input bit wr, input bit ilv, input int addr, input logic [127:0] wd,
                        input int exp_busy, input string dtag, input string rtag,
                        input bit inject);
    int a0;
    int base;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    interleave_en = ilv;
    req_addr = addr[9:0];
    req_wdata = wd;
    @(negedge clk);
    a0 = cyc;
    req_valid = 1'b0;
    interleave_en = ~ilv;
    base = addr & ~3;
    for (int k = 0; k < 4; k++) begin
      if (wr) begin
        ref_mem[base + k] = wd[k*32 +: 32];
      end else begin
        q_data.push_back(ref_mem[base + k]);
        q_cyc.push_back(a0 + 7 + k * (ilv ? 1 : 8));
        q_last.push_back(k == 3);
        q_tag.push_back(dtag);
      end
    end
    if (inject) begin
      // R6: request offered while busy must be ignored
      req_write = 1'b1;
      req_addr = 10'd20;
      req_wdata = {4{32'hDEAD_BEEF}};
      req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    while (!req_ready) @(negedge clk);
    chk(cyc - a0 == exp_busy, {rtag, " ready return cycle"}, cyc - a0, exp_busy);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 valid in reset", rsp_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 valid after reset", rsp_valid, 0);

    do_req(1, 1, 16, pat(16, 1), 7,  "R7", "R7", 0);
    do_req(0, 1, 16, '0,         11, "R3", "R6", 0);
    do_req(1, 1, 20, pat(20, 2), 7,  "R7", "R7", 0);
    do_req(0, 1, 20, '0,         11, "R3", "R6", 0);
    do_req(0, 1, 16, '0,         11, "R2", "R6", 0);
    do_req(1, 0, 40, pat(40, 3), 28, "R9", "R9", 0);
    do_req(0, 0, 40, '0,         32, "R5", "R5", 0);
    do_req(0, 1, 40, '0,         11, "R2", "R6", 0);
    do_req(1, 1, 44, pat(44, 4), 7,  "R7", "R7", 0);
    do_req(0, 0, 44, '0,         32, "R2", "R5", 0);
    do_req(0, 1, 22, '0,         11, "R8", "R6", 0);
    do_req(1, 1, 51, pat(48, 5), 7,  "R8", "R8", 0);
    do_req(0, 1, 48, '0,         11, "R8", "R6", 0);
    do_req(0, 1, 16, '0,         11, "R6", "R6", 1);
    do_req(0, 1, 20, '0,         11, "R6", "R6", 0);
    do_req(0, 1, 40, '0,         11, "R2", "R6", 0);

    repeat (4) @(negedge clk);
    chk(q_data.size() == 0, "R4 all expected words returned", q_data.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule